// File: doc/BRIEF.md
# Internal Bus Parity Control and Error Status Register

This block is one 32-bit software-visible register that governs parity protection on an on-chip bus. Software sets a global switch that turns parity generation and checking on or off. Software also sets four fault-injection controls, which force a deliberately bad parity bit on a chosen kind of bus transfer so that the detection paths can be tested in the field.

Four bus agents each own a sticky error flag in the same register. These agents are a buffer-manager master, an SPI agent, a register bridge and a memory controller. An agent pulses its error input when it detects a bus parity error. The flag then stays set until software reads the register. That read returns the flags as they stood and clears them in the same cycle. The register port is a simple single-cycle request interface. It has no back-pressure: every request is accepted in the cycle it is presented, and each read answers with `reg_rvalid` and `reg_rdata` one cycle later.

Top module: `bus_parity_csr`

## Requirements
- R1: After reset, every control output is 0, so parity is disabled and no injection is active. All error flags are clear, `reg_rvalid` is 0 and `reg_rdata` is 0.
- R2: A write (`reg_valid`=1, `reg_write`=1) to byte address 0x96 loads control bits from `reg_wdata`, and the outputs follow on the next cycle. The mapping is: bit 0 drives `par_en`, bit 1 drives `inj_mst_addr`, bit 2 drives `inj_mst_wr`, bit 3 drives `inj_mem_rd` and bit 4 drives `inj_bridge_rd`.
- R3: A one-cycle pulse on `err_pulse[i]` sets error flag i, and the flag stays set until a read clears it. The index order is: 0 is the memory controller, 1 the register bridge, 2 the SPI agent and 3 the buffer-manager master.
- R4: A read (`reg_valid`=1, `reg_write`=0) always produces a one-cycle `reg_rvalid` pulse on the following cycle. A read of 0x96 returns flag i in `reg_rdata` bit 16+i and control bit k in bit k. Every other bit reads as 0.
- R5: A read of 0x96 clears all error flags. The data returned by that read shows the flags as they were before the clear.
- R6: A pulse that coincides with a clearing read leaves its flag set after the read, so the event is not lost.
- R7: Writes to 0x96 never change the error flags, whatever `reg_wdata` carries in bits 19..16.
- R8: A write to any other address changes nothing. A read of any other address returns 0 and does not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response, one cycle after a read request |
| err_pulse | input | 4 | Parity error pulses from the four agents |
| par_en | output | 1 | Parity generation and check enable |
| inj_mst_addr | output | 1 | Master address parity injection |
| inj_mst_wr | output | 1 | Master write-data parity injection |
| inj_mem_rd | output | 1 | Memory controller read-data parity injection |
| inj_bridge_rd | output | 1 | Register bridge read-data parity injection |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers control outputs after a write, a set flag after a pulse, a cleared flag after a read, and `reg_rvalid` with its data after any read. The bench drives each access and pulse on a falling edge and lets one rising edge pass. It then compares the outputs a moment after that edge against a model it updates at the same point. A flag set by a pulse therefore becomes visible through a read issued at least one cycle later. The collision cases put the pulse and the read in the same cycle on purpose.

// File: rtl/bus_par_pkg.sv
package bus_par_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned NUM_AGENTS = 4;
  localparam int unsigned FLAG_LSB   = 16;
  localparam int unsigned NUM_INJ    = 4;
  localparam int unsigned CTRL_W     = NUM_INJ + 1;

  // Positions of control bits inside the control field
  typedef enum logic [2:0] {
    CB_PAR_EN    = 3'd0,
    CB_MST_ADDR  = 3'd1,
    CB_MST_WR    = 3'd2,
    CB_MEM_RD    = 3'd3,
    CB_BRIDGE_RD = 3'd4
  } ctrl_bit_e;
endpackage

// File: rtl/bpc_flags.sv
module bpc_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // A new event has priority over the clear so no event is dropped
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i)    flags_o[i] <= 1'b0;
    end

    // R3 / R6: a pulse always leaves its flag set
    a_r6_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);
    // R5: a clear without a coinciding pulse empties the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !flags_o[i]);
    // R3: sticky without a clear
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[i] && !clr_i) |=> flags_o[i]);
  end
endmodule

// File: rtl/bpc_ctrl.sv
module bpc_ctrl #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_o <= '0;
    else if (we_i) ctrl_o <= wdata_i;
  end

  // R2: written value appears on the next cycle
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ctrl_o == $past(wdata_i));
  // R8: no write, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/bpc_readback.sv
module bpc_readback #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N        = 4,
  parameter int unsigned FLAG_LSB = 16,
  parameter int unsigned CTRL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              hit_i,
  input  logic [N-1:0]      flags_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((64'd1 << CTRL_W) - 64'd1);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(((64'd1 << N) - 64'd1) << FLAG_LSB);
  localparam logic [DATA_W-1:0] LIVE_MASK = CTRL_MASK | FLAG_MASK;

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    word[CTRL_W-1:0] = ctrl_i;
    word[FLAG_LSB +: N] = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i;
      if (req_i) rdata_o <= hit_i ? word : '0;
    end
  end

  // R4: response one cycle after each read, reserved bits zero
  a_r4_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rvalid_o);
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> (rdata_o & ~LIVE_MASK) == '0);
  // R8: a read elsewhere returns zero
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !hit_i) |=> rdata_o == '0);
endmodule

// File: rtl/bus_parity_csr.sv
module bus_parity_csr
  import bus_par_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_valid,
  input  logic                  reg_write,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  reg_rvalid,
  input  logic [NUM_AGENTS-1:0] err_pulse,
  output logic                  par_en,
  output logic                  inj_mst_addr,
  output logic                  inj_mst_wr,
  output logic                  inj_mem_rd,
  output logic                  inj_bridge_rd
);
  logic                  hit, wr_hit, rd_hit, rd_req;
  logic [NUM_AGENTS-1:0] flags;
  logic [CTRL_W-1:0]     ctrl;
  logic                  unused_wdata;

  assign hit          = reg_valid && (reg_addr == REG_ADDR);
  assign wr_hit       = hit && reg_write;
  assign rd_hit       = hit && !reg_write;
  assign rd_req       = reg_valid && !reg_write;
  assign unused_wdata = ^reg_wdata[DATA_W-1:CTRL_W];

  bpc_flags #(.N(NUM_AGENTS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(err_pulse), .clr_i(rd_hit), .flags_o(flags)
  );

  bpc_ctrl #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_i(wr_hit),
    .wdata_i(reg_wdata[CTRL_W-1:0]), .ctrl_o(ctrl)
  );

  bpc_readback #(
    .DATA_W(DATA_W), .N(NUM_AGENTS), .FLAG_LSB(FLAG_LSB), .CTRL_W(CTRL_W)
  ) u_rb (
    .clk(clk), .rst_n(rst_n), .req_i(rd_req), .hit_i(hit),
    .flags_i(flags), .ctrl_i(ctrl), .rdata_o(reg_rdata), .rvalid_o(reg_rvalid)
  );

  assign par_en        = ctrl[CB_PAR_EN];
  assign inj_mst_addr  = ctrl[CB_MST_ADDR];
  assign inj_mst_wr    = ctrl[CB_MST_WR];
  assign inj_mem_rd    = ctrl[CB_MEM_RD];
  assign inj_bridge_rd = ctrl[CB_BRIDGE_RD];

  // R7: writes never alter flags when no pulse arrives
  a_r7_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && err_pulse == '0) |=> $stable(flags));
  // R8: a miss read does not clear
  a_r8_miss_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !hit) |=> (flags & $past(flags)) == $past(flags));
endmodule

// File: tb/tb_bus_parity_csr.sv
module tb_bus_parity_csr;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] RA = 8'h96;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_rvalid;
  logic [3:0]  err_pulse = '0;
  logic        par_en, inj_mst_addr, inj_mst_wr, inj_mem_rd, inj_bridge_rd;

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_flags = '0;
  logic [4:0] m_ctrl  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_parity_csr dut (.*);

  function automatic logic [31:0] exp_word(input logic [3:0] f, input logic [4:0] c);
    logic [31:0] w = '0;
    w[4:0] = c;
    w[19:16] = f;
    return w;
  endfunction

  function automatic logic [4:0] outs();
    return {inj_bridge_rd, inj_mem_rd, inj_mst_wr, inj_mst_addr, par_en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive on falling edge, check after the rising edge
  task automatic cyc(input logic v, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic [3:0] p, input string req);
    logic [31:0] erd;
    logic        is_rd, is_hit;
    @(negedge clk);
    reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d; err_pulse = p;
    is_rd  = v && !w;
    is_hit = v && (a == RA);
    erd = (is_rd && is_hit) ? exp_word(m_flags, m_ctrl) : 32'h0;
    if (is_hit && is_rd) m_flags = '0;
    m_flags = m_flags | p;
    if (is_hit && w) m_ctrl = d[4:0];
    @(posedge clk); #1;
    check({req, " rvalid"}, {31'h0, reg_rvalid}, {31'h0, is_rd});
    if (is_rd) check({req, " rdata"}, reg_rdata, erd);
    check({req, " ctrl"}, {27'h0, outs()}, {27'h0, m_ctrl});
    reg_valid = 1'b0; err_pulse = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    // R1: reset state
    check("R1 ctrl", {27'h0, outs()}, 32'h0);
    check("R1 rvalid", {31'h0, reg_rvalid}, 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 0, RA, 0, 0, "R1");
    // R2: each control bit, then all
    for (int k = 0; k < 5; k++) cyc(1, 1, RA, 32'h1 << k, 0, "R2");
    cyc(1, 1, RA, 32'hFFFF_FFFF, 0, "R2");
    cyc(1, 0, RA, 0, 0, "R4");
    // R3: pulses accumulate and stick
    cyc(0, 0, 0, 0, 4'b0001, "R3");
    cyc(0, 0, 0, 0, 4'b1000, "R3");
    cyc(0, 0, 0, 0, 0, "R3");
    // R7: writes with flag bits zero and one
    cyc(1, 1, RA, 32'h0000_0000, 0, "R7");
    cyc(1, 1, RA, 32'h000F_0015, 0, "R7");
    // R8: miss accesses
    cyc(1, 1, 8'h95, 32'h0000_001F, 0, "R8");
    cyc(1, 0, 8'h97, 0, 0, "R8");
    // R5: read returns then clears
    cyc(1, 0, RA, 0, 0, "R5");
    cyc(1, 0, RA, 0, 0, "R5");
    // R6: collision keeps flag
    cyc(0, 0, 0, 0, 4'b0110, "R6");
    cyc(1, 0, RA, 0, 4'b0010, "R6");
    cyc(1, 0, RA, 0, 0, "R6");
    cyc(1, 0, RA, 0, 4'b1111, "R6");
    cyc(1, 0, RA, 0, 0, "R6");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      logic [7:0]  a = r[0] ? RA : (r[1] ? 8'(r[15:8]) : RA);
      cyc(r[2], r[3], a, $urandom, (r[4] && r[5]) ? 4'(r[19:16]) : 4'h0, "R4/R5/R6");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule